// File: doc/BRIEF.md
# Search Window Register Array

This block keeps a square window of reference pixels in registers, WIN by WIN bytes, and moves it over a larger square search area of SA_DIM by SA_DIM bytes, which defaults to 2·WIN−1. The search area lives outside the block in one line memory per row. Each line memory returns one byte per clock for the column address the block drives. The block can step the window one column right, one column left or one row down. After each step the whole window is presented in parallel to the downstream SAD process elements.

A horizontal step needs one new byte from each of the WIN line memories under the window, so it always finishes in one clock. A downward step needs a whole new row, and all of that row sits in the single line memory just below the window. To keep that step at one clock, the block holds an extra prefetch row of WIN registers under the window. This row shifts along with the window on horizontal steps. In every cycle without a horizontal step, it is topped up one byte at a time from the line memory below the window. A per-byte mask tracks which entries hold the right data.

If a downward step is requested before the prefetch row is complete, the block stalls and drops its valid flag. It takes the step on the first edge where the row is complete. It never presents a partly fetched row.

Top module: `swin_array`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it until the first load, win_valid, pf_full, top_row and left_col are all 0.
- R2: A one-cycle start pulse moves the window to position (0,0) and fills it over the next WIN clock edges. win_valid stays 0 until the WIN-th of those edges and is 1 after it. The window then equals the search area at (0,0), and pf_full is 1. Byte r·WIN+c of win_pix (bits 8·(r·WIN+c) upward) is always area[top_row+r][left_col+c].
- R3: step with step_dir 2'b00 (right) increments left_col on the same edge. The window contents follow, and the prefetch row stays aligned.
- R4: step with step_dir 2'b10 (left) decrements left_col on the same edge, with the window contents correct.
- R5: step with step_dir 2'b01 (down) while pf_full is 1 increments top_row in one clock with correct contents. pf_full is 0 immediately afterwards.
- R6: In each cycle with no accepted horizontal step, one missing prefetch byte is fetched. After a down step followed by WIN idle cycles, pf_full is 1. After WIN−1 idle cycles it is still 0.
- R7: A held down request while pf_full is 0 stalls, and win_valid is 0 after the first stalled edge. The step is taken on the first edge where the prefetch row is complete. After a down step with no idle cycles, that is WIN+1 edges after the request. win_valid then returns to 1.
- R8: Steps that would leave the search area are ignored: left at column 0, right at column SA_DIM−WIN, and down at row SA_DIM−WIN. step_dir 2'b11 is also ignored. Position, contents and win_valid stay unchanged, and the position never exceeds SA_DIM−WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the window at position (0,0) |
| step | input | 1 | Step request, held until taken |
| step_dir | input | 2 | 00 right, 01 down, 10 left, 11 no move |
| col_addr | output | AW | Column read by the WIN line memories under the window |
| col_data | input | 8·WIN | Byte r = area[top_row+r][col_addr] |
| pf_col | output | AW | Column read by the line memory below the window |
| pf_data | input | 8 | area[top_row+WIN][pf_col], 0 if that row does not exist |
| win_pix | output | 8·WIN·WIN | Window pixels, row-major |
| top_row | output | AW | Window top row in the search area |
| left_col | output | AW | Window left column in the search area |
| win_valid | output | 1 | Window holds the requested position |
| pf_full | output | 1 | Prefetch row complete |

## Verification
The bench builds the block with WIN=4 and SA_DIM=7. At this size every one of the 16 window positions fits inside a short snake scan. It checks each position against a reference extraction from a pseudo-random search area. The small window also makes every refill state reachable in a few cycles: a full row, a row missing one byte after a sweep, and an empty row right after a downward step. This exposes the exact stall lengths and the edge-of-area cases.

// File: rtl/swin_pkg.sv
package swin_pkg;
   typedef enum logic [1:0] {
      DIR_RIGHT = 2'b00,
      DIR_DOWN  = 2'b01,
      DIR_LEFT  = 2'b10,
      DIR_NONE  = 2'b11
   } swin_dir_e;

   typedef enum logic [2:0] {
      ROW_HOLD,
      ROW_SHR,
      ROW_SHL,
      ROW_LOAD,
      ROW_PUT
   } swin_rowop_e;
endpackage

// File: rtl/swin_row.sv
module swin_row
   import swin_pkg::*;
#(
   parameter int WIN = 64,
   parameter int PIX = 8,
   localparam int IW = (WIN > 1) ? $clog2(WIN) : 1,
   localparam int RW = WIN * PIX
) (
   input  logic            clk,
   input  logic            rst_n,
   input  swin_rowop_e     op,
   input  logic [PIX-1:0]  byte_in,
   input  logic [IW-1:0]   put_idx,
   input  logic [RW-1:0]   row_in,
   output logic [RW-1:0]   row_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
      end else begin
         case (op)
            ROW_SHR:  row_q <= {byte_in, row_q[RW-1:PIX]};
            ROW_SHL:  row_q <= {row_q[RW-PIX-1:0], byte_in};
            ROW_LOAD: row_q <= row_in;
            ROW_PUT:  row_q[put_idx*PIX +: PIX] <= byte_in;
            default:  row_q <= row_q;
         endcase
      end
   end
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl
   import swin_pkg::*;
#(
   parameter int WIN    = 64,
   parameter int SA_DIM = 2 * WIN - 1,
   localparam int AW = $clog2(SA_DIM + 1),
   localparam int IW = (WIN > 1) ? $clog2(WIN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          step,
   input  logic [1:0]    step_dir,
   output swin_rowop_e   win_op,
   output swin_rowop_e   pf_op,
   output logic [AW-1:0] col_addr,
   output logic [AW-1:0] pf_col,
   output logic [IW-1:0] put_idx,
   output logic [AW-1:0] top_row,
   output logic [AW-1:0] left_col,
   output logic          win_valid,
   output logic          pf_full
);
   localparam logic [AW-1:0] LAST = AW'(SA_DIM - WIN);
   localparam logic [AW-1:0] W_A  = AW'(WIN);

   logic           loading, primed;
   logic [IW-1:0]  load_cnt;
   logic [WIN-1:0] mask;
   logic [IW-1:0]  gap;
   logic           live, acc_r, acc_l, dn_req, acc_d, stall, fill;

   assign pf_full = &mask;
   assign live    = primed && !loading && !start;
   assign acc_r   = live && step && (step_dir == DIR_RIGHT) && (left_col < LAST);
   assign acc_l   = live && step && (step_dir == DIR_LEFT) && (left_col != '0);
   assign dn_req  = live && step && (step_dir == DIR_DOWN) && (top_row < LAST);
   assign acc_d   = dn_req && pf_full;
   assign stall   = dn_req && !pf_full;
   assign fill    = live && !acc_r && !acc_l && !pf_full && (top_row < LAST);
   assign put_idx = gap;

   always_comb begin
      gap = '0;
      for (int i = WIN - 1; i >= 0; i--)
         if (!mask[i]) gap = IW'(i);
   end

   always_comb begin
      win_op   = ROW_HOLD;
      pf_op    = ROW_HOLD;
      col_addr = left_col;
      pf_col   = left_col;
      if (start) begin
         win_op = ROW_HOLD;
      end else if (loading) begin
         win_op   = ROW_SHR;
         pf_op    = ROW_SHR;
         col_addr = AW'(load_cnt);
         pf_col   = AW'(load_cnt);
      end else if (acc_r) begin
         win_op   = ROW_SHR;
         pf_op    = ROW_SHR;
         col_addr = left_col + W_A;
         pf_col   = left_col + W_A;
      end else if (acc_l) begin
         win_op   = ROW_SHL;
         pf_op    = ROW_SHL;
         col_addr = left_col - 1'b1;
         pf_col   = left_col - 1'b1;
      end else if (acc_d) begin
         win_op = ROW_LOAD;
      end else if (fill) begin
         pf_op  = ROW_PUT;
         pf_col = left_col + AW'(gap);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loading   <= 1'b0;
         primed    <= 1'b0;
         load_cnt  <= '0;
         mask      <= '0;
         top_row   <= '0;
         left_col  <= '0;
         win_valid <= 1'b0;
      end else if (start) begin
         loading   <= 1'b1;
         load_cnt  <= '0;
         mask      <= '0;
         top_row   <= '0;
         left_col  <= '0;
         win_valid <= 1'b0;
      end else if (loading) begin
         mask     <= {1'b1, mask[WIN-1:1]};
         load_cnt <= load_cnt + 1'b1;
         if (load_cnt == IW'(WIN - 1)) begin
            loading   <= 1'b0;
            primed    <= 1'b1;
            win_valid <= 1'b1;
         end
      end else if (acc_r) begin
         left_col  <= left_col + 1'b1;
         mask      <= {1'b1, mask[WIN-1:1]};
         win_valid <= 1'b1;
      end else if (acc_l) begin
         left_col  <= left_col - 1'b1;
         mask      <= {mask[WIN-2:0], 1'b1};
         win_valid <= 1'b1;
      end else if (acc_d) begin
         top_row   <= top_row + 1'b1;
         mask      <= '0;
         win_valid <= 1'b1;
      end else begin
         if (stall) win_valid <= 1'b0;
         if (fill)  mask[gap] <= 1'b1;
      end
   end
endmodule

// File: rtl/swin_array.sv
module swin_array
   import swin_pkg::*;
#(
   parameter int WIN    = 16,
   parameter int SA_DIM = 2 * WIN - 1,
   localparam int PIX = 8,
   localparam int AW  = $clog2(SA_DIM + 1),
   localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1,
   localparam int RW  = WIN * PIX
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  step,
   input  logic [1:0]            step_dir,
   output logic [AW-1:0]         col_addr,
   input  logic [WIN*PIX-1:0]    col_data,
   output logic [AW-1:0]         pf_col,
   input  logic [PIX-1:0]        pf_data,
   output logic [WIN*WIN*PIX-1:0] win_pix,
   output logic [AW-1:0]         top_row,
   output logic [AW-1:0]         left_col,
   output logic                  win_valid,
   output logic                  pf_full
);
   if (WIN < 2) begin : g_bad_win
      $error("swin_array: WIN must be at least 2");
   end
   if (SA_DIM <= WIN) begin : g_bad_sa
      $error("swin_array: SA_DIM must exceed WIN");
   end

   swin_rowop_e   win_op, pf_op;
   logic [IW-1:0] put_idx;
   logic [RW-1:0] win_q [WIN];
   logic [RW-1:0] pf_q;

   swin_ctrl #(.WIN(WIN), .SA_DIM(SA_DIM)) u_ctrl (
      .clk, .rst_n, .start, .step, .step_dir,
      .win_op, .pf_op, .col_addr, .pf_col, .put_idx,
      .top_row, .left_col, .win_valid, .pf_full
   );

   for (genvar r = 0; r < WIN; r++) begin : g_rows
      logic [RW-1:0] below;
      if (r == WIN - 1) begin : g_last
         assign below = pf_q;
      end else begin : g_inner
         assign below = win_q[r+1];
      end
      swin_row #(.WIN(WIN), .PIX(PIX)) u_row (
         .clk, .rst_n, .op(win_op),
         .byte_in(col_data[r*PIX +: PIX]),
         .put_idx, .row_in(below), .row_q(win_q[r])
      );
      assign win_pix[r*RW +: RW] = win_q[r];
   end

   swin_row #(.WIN(WIN), .PIX(PIX)) u_pf_row (
      .clk, .rst_n, .op(pf_op), .byte_in(pf_data),
      .put_idx, .row_in('0), .row_q(pf_q)
   );
endmodule

// File: rtl/swin_chk.sv
module swin_chk #(
   parameter int WIN    = 16,
   parameter int SA_DIM = 2 * WIN - 1,
   localparam int AW = $clog2(SA_DIM + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          step,
   input logic [1:0]    step_dir,
   input logic [AW-1:0] top_row,
   input logic [AW-1:0] left_col,
   input logic          win_valid,
   input logic          pf_full
);
   localparam logic [AW-1:0] LAST = AW'(SA_DIM - WIN);

   // R5: a row advance happens only with a complete prefetch row
   a_r5_down_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      (top_row == $past(top_row) + 1'b1) |-> $past(pf_full));

   // R5: the prefetch row is consumed by the advance
   a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (top_row == $past(top_row) + 1'b1) |-> !pf_full);

   // R7: a stalled down request clears the valid flag
   a_r7_stall_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (step && step_dir == 2'b01 && !pf_full && win_valid && top_row < LAST && !start)
      |=> !win_valid);

   // R8: the window never leaves the search area
   a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (top_row <= LAST) && (left_col <= LAST));

   // R3: a column increase comes only from a right request
   a_r3_right_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (left_col == $past(left_col) + 1'b1) |-> ($past(step) && $past(step_dir) == 2'b00));

   // R4: a column decrease comes only from a left request
   a_r4_left_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (left_col + 1'b1 == $past(left_col)) |-> ($past(step) && $past(step_dir) == 2'b10));

   // R3: one move per edge, never diagonal
   a_r3_single_move: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(top_row) |-> ($stable(left_col) || $past(start)));
endmodule

bind swin_array swin_chk #(.WIN(WIN), .SA_DIM(SA_DIM)) u_chk (
   .clk, .rst_n, .start, .step, .step_dir,
   .top_row, .left_col, .win_valid, .pf_full
);

// File: tb/test_swin_array.sv
`timescale 1ns/1ps
module test_swin_array;
   localparam int W  = 4;
   localparam int SA = 7;
   localparam int AW = $clog2(SA + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic step = 1'b0;
   logic [1:0] step_dir = 2'b11;
   logic [AW-1:0] col_addr, pf_col, top_row, left_col;
   logic [W*8-1:0] col_data;
   logic [7:0] pf_data;
   logic [W*W*8-1:0] win_pix;
   logic win_valid, pf_full;

   logic [7:0] sa [SA][SA];
   int runs = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   swin_array #(.WIN(W), .SA_DIM(SA)) i_swin_array (
      .clk, .rst_n, .start, .step, .step_dir,
      .col_addr, .col_data, .pf_col, .pf_data,
      .win_pix, .top_row, .left_col, .win_valid, .pf_full
   );

   // line memory model: one byte per row per cycle
   always_comb begin
      for (int r = 0; r < W; r++) begin
         int row;
         row = int'(top_row) + r;
         if (row < SA && int'(col_addr) < SA) col_data[r*8 +: 8] = sa[row][int'(col_addr)];
         else col_data[r*8 +: 8] = 8'h00;
      end
      if (int'(top_row) + W < SA && int'(pf_col) < SA)
         pf_data = sa[int'(top_row) + W][int'(pf_col)];
      else
         pf_data = 8'h00;
   end

   // snake scan: {dir, top, left, edges}
   localparam logic [11:0] TBL [15] = '{
      {2'd0, 3'd0, 3'd1, 4'd1}, {2'd0, 3'd0, 3'd2, 4'd1}, {2'd0, 3'd0, 3'd3, 4'd1},
      {2'd1, 3'd1, 3'd3, 4'd1}, {2'd2, 3'd1, 3'd2, 4'd1}, {2'd2, 3'd1, 3'd1, 4'd1},
      {2'd2, 3'd1, 3'd0, 4'd1}, {2'd1, 3'd2, 3'd0, 4'd2}, {2'd0, 3'd2, 3'd1, 4'd1},
      {2'd0, 3'd2, 3'd2, 4'd1}, {2'd0, 3'd2, 3'd3, 4'd1}, {2'd1, 3'd3, 3'd3, 4'd2},
      {2'd2, 3'd3, 3'd2, 4'd1}, {2'd2, 3'd3, 3'd1, 4'd1}, {2'd2, 3'd3, 3'd0, 4'd1}
   };

   task automatic check_eq(input string tag, input int act, input int exp);
      runs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_win(input string tag, input int et, input int el);
      int bad, first_a, first_e;
      bad = 0; first_a = 0; first_e = 0;
      check_eq({tag, " top"}, int'(top_row), et);
      check_eq({tag, " left"}, int'(left_col), el);
      for (int r = 0; r < W; r++)
         for (int c = 0; c < W; c++)
            if (win_pix[(r*W+c)*8 +: 8] != sa[et+r][el+c]) begin
               if (bad == 0) begin
                  first_a = int'(win_pix[(r*W+c)*8 +: 8]);
                  first_e = int'(sa[et+r][el+c]);
               end
               bad++;
            end
      runs++;
      if (bad != 0) begin
         fails++;
         $display("FAIL %s pixels: %0d wrong, first actual %0d expected %0d", tag, bad, first_a, first_e);
      end
   endtask

   task automatic do_load();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (W - 1) @(negedge clk);
   endtask

   task automatic one_step(input logic [1:0] d);
      step = 1'b1; step_dir = d;
      @(negedge clk);
      step = 1'b0; step_dir = 2'b11;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int x;
      x = 32'h1234_5678;
      for (int r = 0; r < SA; r++)
         for (int c = 0; c < SA; c++) begin
            x = x * 1103515245 + 12345;
            sa[r][c] = x[23:16];
         end

      repeat (3) @(negedge clk);
      // R1: reset state
      check_eq("R1 win_valid", int'(win_valid), 0);
      check_eq("R1 pf_full", int'(pf_full), 0);
      check_eq("R1 top", int'(top_row), 0);
      check_eq("R1 left", int'(left_col), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: a step before any load is ignored
      one_step(2'b00);
      check_eq("R1 left after early step", int'(left_col), 0);

      // R2: load
      do_load();
      check_eq("R2 valid one edge early", int'(win_valid), 0);
      @(negedge clk);
      check_eq("R2 win_valid", int'(win_valid), 1);
      check_eq("R2 pf_full", int'(pf_full), 1);
      check_win("R2 load", 0, 0);

      // R3 R4 R5 R7: snake scan over every position
      for (int i = 0; i < 15; i++) begin
         int n, pt, pl;
         pt = int'(top_row); pl = int'(left_col);
         step = 1'b1; step_dir = TBL[i][11:10];
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (int'(top_row) == pt && int'(left_col) == pl && n < 20);
         step = 1'b0; step_dir = 2'b11;
         check_win($sformatf("R3/R4/R5 scan %0d", i), int'(TBL[i][9:7]), int'(TBL[i][6:4]));
         check_eq($sformatf("R5/R7 scan %0d edges", i), n, int'(TBL[i][3:0]));
         check_eq($sformatf("R3 scan %0d valid", i), int'(win_valid), 1);
      end

      // R8: ignored steps at the bottom-left corner
      one_step(2'b10);
      check_win("R8 left at col 0", 3, 0);
      one_step(2'b01);
      check_win("R8 down at last row", 3, 0);
      check_eq("R8 valid after bottom down", int'(win_valid), 1);
      one_step(2'b11);
      check_win("R8 no-move code", 3, 0);
      repeat (3) one_step(2'b00);
      one_step(2'b00);
      check_win("R8 right at last col", 3, 3);

      // R7: down right after down stalls for W+1 edges
      do_load();
      @(negedge clk);
      one_step(2'b00);
      check_win("R3 after reload", 0, 1);
      one_step(2'b01);
      check_win("R5 first down", 1, 1);
      check_eq("R5 pf_full after down", int'(pf_full), 0);
      step = 1'b1; step_dir = 2'b01;
      @(negedge clk);
      check_eq("R7 valid low on stall", int'(win_valid), 0);
      check_eq("R7 top held on stall", int'(top_row), 1);
      repeat (W - 1) @(negedge clk);
      check_eq("R7 still stalled", int'(top_row), 1);
      @(negedge clk);
      step = 1'b0; step_dir = 2'b11;
      check_win("R7 stalled down done", 2, 1);
      check_eq("R7 valid restored", int'(win_valid), 1);

      // R6: idle refill takes exactly W cycles
      repeat (W - 1) @(negedge clk);
      check_eq("R6 not full after W-1", int'(pf_full), 0);
      @(negedge clk);
      check_eq("R6 full after W", int'(pf_full), 1);
      one_step(2'b01);
      check_win("R5 down after idle refill", 3, 1);

      finish_run();
   end
endmodule